// File: doc/BRIEF.md
# Command packet framer

The framer sits between a word-wide command stream and a rendering engine. Every 32-bit word that enters on a valid/ready port is either the head of a command or one of its trailing arguments. The head's top byte is the opcode, and the opcode alone fixes how many argument words follow. The block collects the words of each command in a small word buffer. It offers a command downstream only once every word of it is held, framed by start-of-packet and end-of-packet flags.

As words pass through, the framer keeps shadow copies of the eight environment registers. It patches the texture-page field of environment register 1 from textured primitives, and it rebuilds the drawing bits of a status word. It raises a sticky frame-dirty flag for drawing commands. The two image-transfer opcodes are not forwarded. Their position and size words go to a VRAM transfer engine with a one-cycle start strobe. While that engine reports a write in progress, words that arrive at a command boundary are passed straight to it and are not decoded.

Top module: `cmd_packet_framer`

## Requirements
- R1: A command occupies 1 + N words, where N depends on the opcode in bits 31:24 of its first word. N is 2 for 0x02, 0xA0 and 0xC0. For 0x20-0x3F, N per group of four opcodes in ascending order is 3, 6, 4, 8, 5, 8, 7, 11. N is 2 for 0x40-0x47, 3 for 0x48-0x57 and 4 for 0x58-0x5F. For 0x60-0x7F, N per group of four in ascending order is 2, 3, 1, 0, 1, 2, 1, 2. N is 3 for 0x80 and 0 for every other opcode. Each forwarded command leaves pkt_data_o in arrival order, with pkt_sop_o on its first word only and pkt_eop_o on its last word only.
- R2: pkt_valid_o stays low until the last word of the oldest buffered command has been accepted. A partly received command is held for any number of idle cycles.
- R3: While pkt_valid_o is high and pkt_ready_i is low, pkt_valid_o, pkt_data_o, pkt_sop_o and pkt_eop_o hold their values into the next cycle.
- R4: Opcode 0xA0 (write) and opcode 0xC0 (read) are never forwarded and never stall the input. In the cycle after word 2 of such a command is accepted, xfer_start_o is high for one cycle. In that cycle xfer_pos_o holds word 1, xfer_size_o holds word 2, and xfer_read_o is 1 for 0xC0 and 0 for 0xA0.
- R5: A word offered while wr_busy_i is high and no command is partly received is accepted at once. In the same cycle it appears on wr_data_o with wr_valid_o high. It is neither decoded nor buffered.
- R6: The first word of a command with opcode 0xE0-0xE7 is copied whole into environment register (opcode & 7). Register i appears on env_o[32*i+31:32*i] from the cycle after acceptance.
- R7: After reset, environment register i holds (0xE0+i) << 24. status_o, dirty_o, pkt_valid_o and xfer_start_o are 0.
- R8: If (opcode & 0xF4) == 0x24, bits 8:0 of word 4 replace bits 8:0 of environment register 1. If (opcode & 0xF4) == 0x34, word 5 is used instead. All other bits are kept.
- R9: A first word with opcode 0x02 to 0xBF sets dirty_o from the next cycle. dirty_o stays set until dirty_clr_i is high. A set and a clear in the same cycle leave it set.
- R10: In the cycle after the last word of any decoded command is accepted, status_o[10:0] takes environment register 1 bits 10:0 and status_o[12:11] takes environment register 6 bits 1:0. Both values include that word's own update. status_o[31:13] is 0, and status_o changes at no other time.
- R11: When the 16-word buffer is full, in_ready_o is low for any word that would be buffered. No accepted word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Command word offered |
| in_data_i | input | 32 | Command word |
| in_ready_o | output | 1 | Command word accepted this cycle when valid |
| wr_busy_i | input | 1 | Transfer engine is absorbing write data |
| wr_valid_o | output | 1 | Word passed through to the transfer engine |
| wr_data_o | output | 32 | Passed-through word |
| pkt_valid_o | output | 1 | Packet word available |
| pkt_data_o | output | 32 | Packet word |
| pkt_sop_o | output | 1 | First word of a packet |
| pkt_eop_o | output | 1 | Last word of a packet |
| pkt_ready_i | input | 1 | Renderer takes the packet word |
| xfer_start_o | output | 1 | One-cycle transfer start strobe |
| xfer_read_o | output | 1 | Transfer direction, 1 = read |
| xfer_pos_o | output | 32 | Transfer position word |
| xfer_size_o | output | 32 | Transfer size word |
| env_o | output | 256 | Environment register shadows, register i at bits 32*i+31:32*i |
| status_o | output | 32 | Drawing status bits |
| dirty_o | output | 1 | Frame-dirty flag |
| dirty_clr_i | input | 1 | Clears the frame-dirty flag |

## Verification
A table-driven sweep sends one command of each length class back to back. It separates a wrong length decode from a wrong framing flag, because every boundary error shifts every later start flag. A command is stopped part-way and left idle, which shows whether the output waits for completion or cuts through. A held output with a stream of single-word commands fills the buffer and exposes any lost or extra word. Transfer commands followed by pass-through words, including words that look like environment writes, separate routing from decoding. A long random mix of opcodes, gaps, stalls, pass-through words and flag clears then shows that the texture snoop, status rebuild and dirty flag agree with the model at every cycle.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  localparam int WORD_W    = 32;
  localparam int ENV_N     = 8;
  localparam int MAX_PKT   = 12;
  localparam int LEN_W     = $clog2(MAX_PKT + 1);
  localparam logic [7:0] OP_IMG_WR = 8'hA0;
  localparam logic [7:0] OP_IMG_RD = 8'hC0;

  typedef struct packed {
    logic              sop;
    logic              eop;
    logic [WORD_W-1:0] data;
  } buf_word_t;

  function automatic logic [LEN_W-1:0] extra_words(input logic [7:0] op);
    logic [LEN_W-1:0] n;
    case (op) inside
      8'h02, 8'hA0, 8'hC0:        n = LEN_W'(2);
      [8'h20:8'h23]:              n = LEN_W'(3);
      [8'h24:8'h27]:              n = LEN_W'(6);
      [8'h28:8'h2B]:              n = LEN_W'(4);
      [8'h2C:8'h2F]:              n = LEN_W'(8);
      [8'h30:8'h33]:              n = LEN_W'(5);
      [8'h34:8'h37]:              n = LEN_W'(8);
      [8'h38:8'h3B]:              n = LEN_W'(7);
      [8'h3C:8'h3F]:              n = LEN_W'(11);
      [8'h40:8'h47]:              n = LEN_W'(2);
      [8'h48:8'h57]:              n = LEN_W'(3);
      [8'h58:8'h5F]:              n = LEN_W'(4);
      [8'h60:8'h63]:              n = LEN_W'(2);
      [8'h64:8'h67]:              n = LEN_W'(3);
      [8'h68:8'h6B]:              n = LEN_W'(1);
      [8'h70:8'h73]:              n = LEN_W'(1);
      [8'h74:8'h77]:              n = LEN_W'(2);
      [8'h78:8'h7B]:              n = LEN_W'(1);
      [8'h7C:8'h7F]:              n = LEN_W'(2);
      8'h80:                      n = LEN_W'(3);
      default:                    n = '0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/cpf_decode.sv
module cpf_decode
  import cpf_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [7:0]        op_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              img_o,
  output logic              img_rd_o
);
  assign op_o     = word_i[WORD_W-1 -: 8];
  assign len_o    = extra_words(op_o) + LEN_W'(1);
  assign img_o    = (op_o == OP_IMG_WR) || (op_o == OP_IMG_RD);
  assign img_rd_o = (op_o == OP_IMG_RD);
endmodule

// File: rtl/cpf_fifo.sv
module cpf_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/cpf_env.sv
module cpf_env
  import cpf_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    take_i,
  input  logic                    first_i,
  input  logic                    last_i,
  input  logic [7:0]              op_i,
  input  logic [LEN_W-1:0]        idx_i,
  input  logic [WORD_W-1:0]       data_i,
  input  logic                    dirty_clr_i,
  output logic [ENV_N*WORD_W-1:0] env_o,
  output logic [WORD_W-1:0]       status_o,
  output logic                    dirty_o
);
  logic [WORD_W-1:0] env_q [ENV_N];
  logic [WORD_W-1:0] env_d [ENV_N];
  logic [WORD_W-1:0] status_q;
  logic              dirty_q;
  logic              env_hit, tex_hit, dirty_hit;

  assign env_hit   = take_i && first_i && (op_i[7:3] == 5'b11100);
  assign tex_hit   = take_i &&
                     ((((op_i & 8'hF4) == 8'h24) && (idx_i == LEN_W'(4))) ||
                      (((op_i & 8'hF4) == 8'h34) && (idx_i == LEN_W'(5))));
  assign dirty_hit = take_i && first_i && (op_i >= 8'h02) && (op_i < 8'hC0);

  always_comb begin
    for (int i = 0; i < ENV_N; i++) env_d[i] = env_q[i];
    if (env_hit) env_d[op_i[2:0]] = data_i;
    if (tex_hit) env_d[1][8:0] = data_i[8:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENV_N; i++) env_q[i] <= {8'(8'hE0 + i), 24'h0};
      status_q <= '0;
      dirty_q  <= 1'b0;
    end else begin
      for (int i = 0; i < ENV_N; i++) env_q[i] <= env_d[i];
      if (take_i && last_i)
        status_q <= {19'h0, env_d[6][1:0], env_d[1][10:0]};
      if (dirty_hit)        dirty_q <= 1'b1;
      else if (dirty_clr_i) dirty_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < ENV_N; g++) begin : g_env_out
    assign env_o[g*WORD_W +: WORD_W] = env_q[g];
  end

  assign status_o = status_q;
  assign dirty_o  = dirty_q;
endmodule

// File: rtl/cmd_packet_framer.sv
module cmd_packet_framer
  import cpf_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic [WORD_W-1:0]       in_data_i,
  output logic                    in_ready_o,
  input  logic                    wr_busy_i,
  output logic                    wr_valid_o,
  output logic [WORD_W-1:0]       wr_data_o,
  output logic                    pkt_valid_o,
  output logic [WORD_W-1:0]       pkt_data_o,
  output logic                    pkt_sop_o,
  output logic                    pkt_eop_o,
  input  logic                    pkt_ready_i,
  output logic                    xfer_start_o,
  output logic                    xfer_read_o,
  output logic [WORD_W-1:0]       xfer_pos_o,
  output logic [WORD_W-1:0]       xfer_size_o,
  output logic [ENV_N*WORD_W-1:0] env_o,
  output logic [WORD_W-1:0]       status_o,
  output logic                    dirty_o,
  input  logic                    dirty_clr_i
);
  localparam int BUF_W = $bits(buf_word_t);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  // word position inside the command being received
  logic [LEN_W-1:0]  idx_q, len_q;
  logic [7:0]        op_q;
  logic              img_q, img_rd_q;
  logic              start_q, rd_q;
  logic [WORD_W-1:0] pos_q, size_q;
  logic [CNT_W-1:0]  done_cnt_q;

  logic [7:0]        dec_op;
  logic [LEN_W-1:0]  dec_len;
  logic              dec_img, dec_img_rd;

  logic              first, route, cur_img, take, last, push, pop;
  logic [7:0]        cur_op;
  logic [LEN_W-1:0]  cur_len;
  logic              buf_full, buf_empty;
  buf_word_t         push_w, head_w;

  cpf_decode u_dec (
    .word_i   (in_data_i),
    .op_o     (dec_op),
    .len_o    (dec_len),
    .img_o    (dec_img),
    .img_rd_o (dec_img_rd)
  );

  assign first   = (idx_q == '0);
  assign route   = wr_busy_i && first;
  assign cur_img = first ? dec_img : img_q;
  assign cur_op  = first ? dec_op  : op_q;
  assign cur_len = first ? dec_len : len_q;

  assign in_ready_o = route || cur_img || !buf_full;
  assign take       = in_valid_i && in_ready_o && !route;
  assign last       = (idx_q == cur_len - LEN_W'(1));
  assign push       = take && !cur_img;

  assign wr_valid_o = in_valid_i && route;
  assign wr_data_o  = in_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      len_q    <= LEN_W'(1);
      op_q     <= '0;
      img_q    <= 1'b0;
      img_rd_q <= 1'b0;
    end else if (take) begin
      idx_q <= last ? '0 : idx_q + LEN_W'(1);
      if (first) begin
        len_q    <= dec_len;
        op_q     <= dec_op;
        img_q    <= dec_img;
        img_rd_q <= dec_img_rd;
      end
    end
  end

  // image transfer hand-off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      rd_q    <= 1'b0;
      pos_q   <= '0;
      size_q  <= '0;
    end else begin
      start_q <= 1'b0;
      if (take && cur_img && !first) begin
        if (idx_q == LEN_W'(1)) pos_q <= in_data_i;
        if (idx_q == LEN_W'(2)) begin
          size_q  <= in_data_i;
          rd_q    <= img_rd_q;
          start_q <= 1'b1;
        end
      end
    end
  end

  assign xfer_start_o = start_q;
  assign xfer_read_o  = rd_q;
  assign xfer_pos_o   = pos_q;
  assign xfer_size_o  = size_q;

  assign push_w = '{sop: first, eop: last, data: in_data_i};

  cpf_fifo #(.W(BUF_W), .DEPTH(FIFO_DEPTH)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (push_w),
    .pop_i       (pop),
    .head_o      (head_w),
    .empty_o     (buf_empty),
    .full_o      (buf_full)
  );

  // number of buffered commands whose last word has arrived
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_cnt_q <= '0;
    end else begin
      case ({push && last, pop && head_w.eop})
        2'b10:   done_cnt_q <= done_cnt_q + CNT_W'(1);
        2'b01:   done_cnt_q <= done_cnt_q - CNT_W'(1);
        default: done_cnt_q <= done_cnt_q;
      endcase
    end
  end

  assign pkt_valid_o = !buf_empty && (done_cnt_q != '0);
  assign pkt_data_o  = head_w.data;
  assign pkt_sop_o   = head_w.sop;
  assign pkt_eop_o   = head_w.eop;
  assign pop         = pkt_valid_o && pkt_ready_i;

  cpf_env u_env (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .first_i     (first),
    .last_i      (last),
    .op_i        (cur_op),
    .idx_i       (idx_q),
    .data_i      (in_data_i),
    .dirty_clr_i (dirty_clr_i),
    .env_o       (env_o),
    .status_o    (status_o),
    .dirty_o     (dirty_o)
  );

  initial begin
    if (FIFO_DEPTH < MAX_PKT) $error("FIFO_DEPTH below longest command");
  end
endmodule

// File: rtl/cpf_checker.sv
module cpf_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        wr_busy_i,
  input logic        wr_valid_o,
  input logic        pkt_valid_o,
  input logic [31:0] pkt_data_o,
  input logic        pkt_sop_o,
  input logic        pkt_eop_o,
  input logic        pkt_ready_i,
  input logic        xfer_start_o,
  input logic        dirty_o,
  input logic        dirty_clr_i
);
  logic mid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mid_q <= 1'b0;
    else if (pkt_valid_o && pkt_ready_i) mid_q <= !pkt_eop_o;
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && !pkt_ready_i |=> pkt_valid_o && $stable(pkt_data_o) &&
                                    $stable(pkt_sop_o) && $stable(pkt_eop_o)); // R3
  AST_SOP_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && pkt_sop_o |-> !mid_q); // R1
  AST_BODY_INSIDE_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && !pkt_sop_o |-> mid_q); // R1
  AST_XFER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o); // R4
  AST_WR_ROUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> in_valid_i && in_ready_o && wr_busy_i); // R5
  AST_DIRTY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_o && !dirty_clr_i |=> dirty_o); // R9
endmodule

bind cmd_packet_framer cpf_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .wr_busy_i    (wr_busy_i),
  .wr_valid_o   (wr_valid_o),
  .pkt_valid_o  (pkt_valid_o),
  .pkt_data_o   (pkt_data_o),
  .pkt_sop_o    (pkt_sop_o),
  .pkt_eop_o    (pkt_eop_o),
  .pkt_ready_i  (pkt_ready_i),
  .xfer_start_o (xfer_start_o),
  .dirty_o      (dirty_o),
  .dirty_clr_i  (dirty_clr_i)
);

// File: tb/cmd_packet_framer_test.sv
module cmd_packet_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [31:0]  in_data_i = '0;
  logic         in_ready_o;
  logic         wr_busy_i = 1'b0;
  logic         wr_valid_o;
  logic [31:0]  wr_data_o;
  logic         pkt_valid_o;
  logic [31:0]  pkt_data_o;
  logic         pkt_sop_o, pkt_eop_o;
  logic         pkt_ready_i = 1'b0;
  logic         xfer_start_o, xfer_read_o;
  logic [31:0]  xfer_pos_o, xfer_size_o;
  logic [255:0] env_o;
  logic [31:0]  status_o;
  logic         dirty_o;
  logic         dirty_clr_i = 1'b0;

  cmd_packet_framer uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int rdy_mode = 1;   // 0 stall, 1 always, 2 random
  bit dense = 1, rnd_clr = 0;

  logic [31:0] stim_d[$];
  bit          stim_b[$];

  // reference model state
  logic [31:0] mq_d[$];
  bit          mq_s[$], mq_e[$];
  int          mcomp, midx, mlen, mop;
  bit          mimg, mrd_cur, mxs, mrd, mdirty;
  logic [31:0] menv[8];
  logic [31:0] mpos, msize, mstat;

  function automatic int ext(int op);
    int g;
    if (op == 'h02 || op == 'hA0 || op == 'hC0) return 2;
    if (op >= 'h20 && op <= 'h3F) begin
      g = (op - 'h20) / 4;
      case (g) 0: return 3; 1: return 6; 2: return 4; 3: return 8;
        4: return 5; 5: return 8; 6: return 7; default: return 11;
      endcase
    end
    if (op >= 'h40 && op <= 'h47) return 2;
    if (op >= 'h48 && op <= 'h57) return 3;
    if (op >= 'h58 && op <= 'h5F) return 4;
    if (op >= 'h60 && op <= 'h7F) begin
      g = (op - 'h60) / 4;
      case (g) 0: return 2; 1: return 3; 2: return 1; 3: return 0;
        4: return 1; 5: return 2; 6: return 1; default: return 2;
      endcase
    end
    if (op == 'h80) return 3;
    return 0;
  endfunction

  function automatic bit isimg(int op);
    return op == 'hA0 || op == 'hC0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit m_ready();
    bit route, imgw;
    route = wr_busy_i && midx == 0;
    imgw  = (midx == 0) ? isimg(int'(in_data_i[31:24])) : mimg;
    return route || imgw || (mq_d.size() < DEPTH);
  endfunction

  function automatic bit m_valid();
    return mq_d.size() > 0 && mcomp > 0;
  endfunction

  task automatic m_reset();
    mq_d.delete(); mq_s.delete(); mq_e.delete();
    mcomp = 0; midx = 0; mlen = 1; mop = 0; mimg = 0; mrd_cur = 0;
    mxs = 0; mrd = 0; mdirty = 0; mpos = 0; msize = 0; mstat = 0;
    for (int i = 0; i < 8; i++) menv[i] = (32'hE0 + i) << 24;
  endtask

  // model update at the active edge, from bench-driven inputs only
  always @(posedge clk_i) begin
    cyc++;
    if (!rst_ni) m_reset();
    else begin
      bit hs, route, first, last, setd;
      hs    = in_valid_i && m_ready();
      route = wr_busy_i && midx == 0;
      mxs   = 0;
      if (m_valid() && pkt_ready_i) begin
        if (mq_e[0]) mcomp--;
        void'(mq_d.pop_front()); void'(mq_s.pop_front()); void'(mq_e.pop_front());
      end
      setd = 0;
      if (hs && !route) begin
        first = (midx == 0);
        if (first) begin
          mop = int'(in_data_i[31:24]);
          mlen = 1 + ext(mop);
          mimg = isimg(mop);
          mrd_cur = (mop == 'hC0);
          if (mop >= 'h02 && mop < 'hC0) setd = 1;
          if (mop >= 'hE0 && mop <= 'hE7) menv[mop - 'hE0] = in_data_i;
        end
        if ((((mop & 'hF4) == 'h24) && midx == 4) || (((mop & 'hF4) == 'h34) && midx == 5))
          menv[1][8:0] = in_data_i[8:0];
        last = (midx == mlen - 1);
        if (mimg) begin
          if (midx == 1) mpos = in_data_i;
          if (midx == 2) begin msize = in_data_i; mxs = 1; mrd = mrd_cur; end
        end else begin
          mq_d.push_back(in_data_i); mq_s.push_back(first); mq_e.push_back(last);
          if (last) mcomp++;
        end
        if (last) begin
          mstat = {19'h0, menv[6][1:0], menv[1][10:0]};
          midx = 0;
        end else midx++;
      end
      if (setd) mdirty = 1;
      else if (dirty_clr_i) mdirty = 0;
      if (hs) begin void'(stim_d.pop_front()); void'(stim_b.pop_front()); end
    end
  end

  // compare registered state, drive inputs, compare combinational outputs
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit mv;
      mv = m_valid();
      chk(pkt_valid_o == mv, "R2", pkt_valid_o, mv);
      if (mv && pkt_valid_o) begin
        chk(pkt_data_o == mq_d[0], "R1", pkt_data_o, mq_d[0]);
        chk({pkt_sop_o, pkt_eop_o} == {mq_s[0], mq_e[0]}, "R1", {pkt_sop_o, pkt_eop_o}, {mq_s[0], mq_e[0]});
      end
      for (int i = 0; i < 8; i++)
        chk(env_o[32*i +: 32] == menv[i], "R6/R8", env_o[32*i +: 32], menv[i]);
      chk(status_o == mstat, "R10", status_o, mstat);
      chk(dirty_o == mdirty, "R9", dirty_o, mdirty);
      chk(xfer_start_o == mxs, "R4", xfer_start_o, mxs);
      if (mxs) begin
        chk(xfer_pos_o == mpos, "R4", xfer_pos_o, mpos);
        chk(xfer_size_o == msize, "R4", xfer_size_o, msize);
        chk(xfer_read_o == mrd, "R4", xfer_read_o, mrd);
      end
    end
    if (stim_d.size() > 0 && (dense || ($urandom % 4) != 0)) begin
      in_valid_i = 1'b1; in_data_i = stim_d[0]; wr_busy_i = stim_b[0];
    end else begin
      in_valid_i = 1'b0; in_data_i = $urandom; wr_busy_i = ($urandom % 2) == 0;
    end
    pkt_ready_i = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 0) ? 1'b0 : (($urandom % 3) != 0);
    dirty_clr_i = rnd_clr && (($urandom % 16) == 0);
    #1;
    if (rst_ni && !done) begin
      bit mr, mw;
      mr = m_ready();
      mw = in_valid_i && wr_busy_i && midx == 0;
      chk(in_ready_o == mr, "R11", in_ready_o, mr);
      chk(wr_valid_o == mw, "R5", wr_valid_o, mw);
      if (mw) chk(wr_data_o == in_data_i, "R5", wr_data_o, in_data_i);
    end
  end

  task automatic send_cmd(input int op, input bit busy = 0);
    int n;
    n = 1 + ext(op);
    for (int k = 0; k < n; k++) begin
      stim_d.push_back((k == 0) ? {8'(op), 24'($urandom)} : 32'($urandom));
      stim_b.push_back(busy);
    end
  endtask

  task automatic push_word(input logic [31:0] w, input bit busy);
    stim_d.push_back(w); stim_b.push_back(busy);
  endtask

  task automatic drain();
    while (stim_d.size() > 0 || mq_d.size() > 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    int ops[$];
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #2;
    // R7: reset state
    for (int i = 0; i < 8; i++)
      chk(env_o[32*i +: 32] == ((32'hE0 + i) << 24), "R7", env_o[32*i +: 32], (32'hE0 + i) << 24);
    chk({status_o, dirty_o, pkt_valid_o, xfer_start_o} == '0, "R7",
        {status_o, dirty_o, pkt_valid_o, xfer_start_o}, 0);

    // R1/R8/R6/R10: one command of each length class
    ops = '{'h00, 'h02, 'h20, 'h24, 'h28, 'h2C, 'h30, 'h34, 'h38, 'h3C, 'h40, 'h48, 'h58,
            'h60, 'h64, 'h68, 'h6C, 'h70, 'h74, 'h78, 'h7C, 'h80, 'hE1, 'hE6, 'hE3, 'hFF};
    foreach (ops[i]) send_cmd(ops[i]);
    drain();

    // R2: partial command held while idle
    push_word(32'h2C00_0001, 0); push_word(32'h1, 0); push_word(32'h2, 0);
    while (stim_d.size() > 0) @(negedge clk_i);
    repeat (8) @(negedge clk_i);
    #2 chk(pkt_valid_o == 1'b0, "R2", pkt_valid_o, 0);
    for (int k = 0; k < 6; k++) push_word(32'h100 + k, 0);
    drain();

    // R11/R3: downstream stalled, buffer fills
    rdy_mode = 0;
    for (int k = 0; k < 20; k++) push_word({8'h01, 24'(k)}, 0);
    repeat (30) @(negedge clk_i);
    #2 chk(in_ready_o == 1'b0, "R11", in_ready_o, 0);
    chk(pkt_valid_o == 1'b1, "R3", pkt_valid_o, 1);
    rdy_mode = 1;
    drain();

    // R4/R5: transfers and pass-through words that look like commands
    push_word(32'hA000_0000, 0); push_word(32'h0010_0020, 0); push_word(32'h0004_0008, 0);
    push_word(32'hE5AB_CDEF, 1); push_word(32'h2800_0000, 1); push_word(32'h0200_0000, 1);
    send_cmd('h20);
    push_word(32'hC000_0000, 0); push_word(32'h0001_0002, 0); push_word(32'h0003_0004, 0);
    send_cmd('hE6);
    drain();

    // random mix
    dense = 0; rdy_mode = 2; rnd_clr = 1;
    for (int p = 0; p < 400; p++) begin
      int op;
      op = (($urandom % 4) == 0) ? int'(8'hE0 + ($urandom % 8)) : int'($urandom % 256);
      send_cmd(op, 0);
      if (($urandom % 8) == 0) begin
        stim_b[stim_b.size() - 1 - ext(op)] = 1;
      end
      if (stim_d.size() > 40) while (stim_d.size() > 10) @(negedge clk_i);
    end
    drain();
    done = 1;
    summary();
  end
endmodule